// File: doc/BRIEF.md
# Tone-Burst DDS Generator

This block drives a waveform memory to produce a train of windowed tone bursts, used to excite a transducer. The stored waveform is one burst: a tone of a few cycles shaped by a raised-cosine envelope. A phase accumulator steps through the memory by a frequency control word on every enable tick. The tick is the system clock divided down by a fixed ratio. When the accumulated phase passes the end of the table, the accumulator clears and the burst ends. The table is never swept twice in a row. A repetition timer restarts the next burst on a fixed schedule, measured from the start of one burst to the start of the next.

The memory sits outside the block and answers an address after one clock. The block registers the returned sample and flags whether it belongs to a burst. Between bursts it outputs the mid-scale code. The output is a stream with `sample_valid_o` as its valid and no ready. The generator runs at a fixed rate and cannot wait, so the consumer, normally a DAC, must accept every sample. `sample_o` and `burst_active_o` hold their values between valid pulses.

Top module: `tone_burst_dds`

## Requirements
- R1: `sample_valid_o` is a single-cycle pulse issued once every TICK_DIV clock cycles (default 10), one pulse per enable tick.
- R2: Within a burst with control word K, the samples come from the memory addresses 0, K, 2K, 3K, ... in that order. Each address is the low ADDR_W bits of the accumulated phase (ADDR_W defaults to 14).
- R3: A burst ends on the tick where phase plus K reaches 2^ADDR_W, which sets accumulator bit ADDR_W (bit 14 by default). The accumulator then clears to zero. A burst therefore holds exactly ceil(2^ADDR_W / K) active samples, and the sample that follows it is idle.
- R4: When a burst is shorter than PERIOD_TICKS (default 5000 ticks, i.e. 1 ms at a 5 MHz tick), consecutive bursts start exactly PERIOD_TICKS ticks apart.
- R5: When a burst needs PERIOD_TICKS ticks or more, the next burst starts on the tick that follows its end. The start-to-start spacing is then ceil(2^ADDR_W / K) + 1 ticks.
- R6: The control word is captured on the tick that starts a burst. A change of `fcw_i` during a burst has no effect on that burst's addresses.
- R7: Every sample outside a burst has `burst_active_o` = 0 and `sample_o` = 2048, the mid-scale code 2^(SAMPLE_W-1).
- R8: Every burst sample has `burst_active_o` = 1 and `sample_o` equal to the memory word for its address. The memory word is sampled one clock after the address is presented. `sample_o` and `burst_active_o` change only in a cycle where `sample_valid_o` is high.
- R9: While `rst` (synchronous, active high) is asserted, `sample_o` = 2048, `burst_active_o` = 0 and `sample_valid_o` = 0. The first burst starts on the first tick after release.
- R10: `mem_addr_o` is a register. It changes only in the cycle after an enable tick, so it stays stable for at least TICK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_i | input | FCW_W (8) | Frequency control word K, must be non-zero |
| mem_addr_o | output | ADDR_W (14) | Registered waveform memory address |
| mem_data_i | input | SAMPLE_W (12) | Memory word, valid one clock after its address |
| sample_o | output | SAMPLE_W (12) | Output sample, held between valid pulses |
| sample_valid_o | output | 1 | One-cycle strobe per sample; no back-pressure |
| burst_active_o | output | 1 | High while the held sample belongs to a burst |

## Verification
The embedded properties rely on three facts about the inputs. The memory returns the word for an address exactly one clock later. The control word is never zero, because a zero word would hold the phase at zero and a burst would never end. TICK_DIV is at least three, so the memory word arrives before the address moves again. The bench follows all three: its memory model is a single register stage over a computed function of the address, and every control word it applies lies between 1 and 255. It runs with a shortened table, tick ratio and period so that both the normal repetition case and the overrun case fit in a short run. It also rewrites `fcw_i` in the middle of every burst.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Burst engine state: waiting for the repetition timer, or sweeping the table.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } burst_state_e;

  // Default geometry of the generator.
  localparam int DEF_ADDR_W     = 14;
  localparam int DEF_FCW_W      = 8;
  localparam int DEF_SAMPLE_W   = 12;
  localparam int DEF_TICK_DIV   = 10;
  localparam int DEF_PERIOD_TCK = 5000;

endpackage

// File: rtl/dds_tick_gen.sv
module dds_tick_gen #(
  parameter int TICK_DIV = dds_pkg::DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/dds_period_timer.sv
module dds_period_timer #(
  parameter int PERIOD_TICKS = dds_pkg::DEF_PERIOD_TCK
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  output logic ready_o
);
  localparam int CNT_W = $clog2(PERIOD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  // Saturates at LAST; a burst may start once it is reached.
  assign ready_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LAST;            // first burst fires on the first tick
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (tick_i && !ready_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    start_i |-> tick_i); // R4

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int FCW_W  = DEF_FCW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ready_i,
  input  logic [FCW_W-1:0]  fcw_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic              stb_o
);
  localparam int SUM_W = ADDR_W + 1;

  burst_state_e      st_q;
  logic [ADDR_W-1:0] phase_q;
  logic [FCW_W-1:0]  fcw_q;
  logic [SUM_W-1:0]  sum;

  // Accumulator with one extra bit: its top bit marks the end of the table.
  assign sum     = {1'b0, phase_q} + SUM_W'(fcw_q);
  assign start_o = tick_i && (st_q == ST_IDLE) && ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      phase_q    <= '0;
      fcw_q      <= '0;
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
      stb_o      <= 1'b0;
    end else begin
      stb_o <= tick_i;
      if (tick_i) begin
        addr_o     <= phase_q;
        addr_vld_o <= (st_q == ST_RUN);
        if (st_q == ST_RUN) begin
          if (sum[ADDR_W]) begin
            phase_q <= '0;
            st_q    <= ST_IDLE;
          end else begin
            phase_q <= sum[ADDR_W-1:0];
          end
        end else if (ready_i) begin
          st_q    <= ST_RUN;
          phase_q <= '0;
          fcw_q   <= fcw_i;
        end
      end
    end
  end

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(st_q == ST_RUN) |-> (phase_q == '0)); // R3

  AST_FCW_HELD: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RUN) && $past(st_q == ST_RUN)) |-> $stable(fcw_q)); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_i) |-> $stable(addr_o)); // R10

endmodule

// File: rtl/dds_out_stage.sv
module dds_out_stage #(
  parameter int SAMPLE_W = dds_pkg::DEF_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stb_i,
  input  logic                vld_i,
  input  logic [SAMPLE_W-1:0] mem_data_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                active_o
);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic stb_d_q;

  // The strobe is delayed by one clock to cover the memory read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d_q  <= 1'b0;
      sample_o <= MID;
      valid_o  <= 1'b0;
      active_o <= 1'b0;
    end else begin
      stb_d_q <= stb_i;
      valid_o <= stb_d_q;
      if (stb_d_q) begin
        sample_o <= vld_i ? mem_data_i : MID;
        active_o <= vld_i;
      end
    end
  end

  AST_IDLE_MID: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (sample_o == MID)); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R1

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(sample_o) && $stable(active_o))); // R8

endmodule

// File: rtl/tone_burst_dds.sv
module tone_burst_dds
  import dds_pkg::*;
#(
  parameter int ADDR_W       = DEF_ADDR_W,
  parameter int FCW_W        = DEF_FCW_W,
  parameter int SAMPLE_W     = DEF_SAMPLE_W,
  parameter int TICK_DIV     = DEF_TICK_DIV,
  parameter int PERIOD_TICKS = DEF_PERIOD_TCK
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FCW_W-1:0]    fcw_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [SAMPLE_W-1:0] mem_data_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                burst_active_o
);
  logic tick, ready, start, addr_vld, stb;

  initial begin
    if (TICK_DIV < 3) $error("TICK_DIV must be at least 3");
    if (ADDR_W + 1 < FCW_W) $error("accumulator narrower than control word");
  end

  dds_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  dds_period_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .start_i (start),
    .ready_o (ready)
  );

  dds_phase_core #(.ADDR_W(ADDR_W), .FCW_W(FCW_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .ready_i    (ready),
    .fcw_i      (fcw_i),
    .start_o    (start),
    .addr_o     (mem_addr_o),
    .addr_vld_o (addr_vld),
    .stb_o      (stb)
  );

  dds_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .stb_i      (stb),
    .vld_i      (addr_vld),
    .mem_data_i (mem_data_i),
    .sample_o   (sample_o),
    .valid_o    (sample_valid_o),
    .active_o   (burst_active_o)
  );

endmodule

// File: tb/sim_tone_burst_dds.sv
module sim_tone_burst_dds;
  localparam int AW  = 8;
  localparam int FW  = 8;
  localparam int SW  = 12;
  localparam int DIV = 4;
  localparam int PER = 100;
  localparam int NB  = 6;
  localparam int MIDV = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [FW-1:0] fcw = 8'd23;
  logic [AW-1:0] maddr;
  logic [SW-1:0] mdata = '0;
  logic [SW-1:0] samp;
  logic          sv, act;

  tone_burst_dds #(
    .ADDR_W(AW), .FCW_W(FW), .SAMPLE_W(SW), .TICK_DIV(DIV), .PERIOD_TICKS(PER)
  ) u0 (
    .clk(clk), .rst(rst), .fcw_i(fcw), .mem_addr_o(maddr), .mem_data_i(mdata),
    .sample_o(samp), .sample_valid_o(sv), .burst_active_o(act)
  );

  function automatic logic [SW-1:0] memf(int a);
    return SW'((a * 37 + 11) % 4096);
  endfunction

  // Memory model: one clock of read latency.
  always @(posedge clk) mdata <= memf(int'(maddr));

  typedef struct {
    logic          a;
    logic [SW-1:0] s;
    string         tag;
  } item_t;

  item_t q[$];
  item_t e_it;
  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;
  int kl[NB] = '{23, 1, 255, 64, 100, 37};

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int blen(int k);
    return ((1 << AW) + k - 1) / k;
  endfunction

  function automatic int dlen(int k);
    return (blen(k) + 1 > PER) ? blen(k) + 1 : PER;
  endfunction

  // Driver: expected output items of one whole burst period.
  task automatic push_burst(int k, int b);
    item_t it;
    int l = blen(k);
    int d = dlen(k);
    it.a = 1'b0; it.s = SW'(MIDV);
    it.tag = (b == 0) ? "R9 R7 start" : "R7 start";
    q.push_back(it);
    for (int i = 0; i < l; i++) begin
      it.a = 1'b1; it.s = memf(i * k);
      it.tag = "R2 R6 R8 burst";
      q.push_back(it);
    end
    for (int i = 0; i < d - 1 - l; i++) begin
      it.a = 1'b0; it.s = SW'(MIDV);
      it.tag = (i == 0) ? "R3 R7 end" : "R7 gap";
      q.push_back(it);
    end
  endtask

  // Monitor: compare against the scoreboard away from the active edge.
  int last_v = -1, last_rise = 0, rises = 0, last_chg = -1, gap = 0;
  bit prev_act = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sv) begin
        if (last_v >= 0) check(cyc - last_v == DIV, "R1 valid spacing", cyc - last_v, DIV);
        last_v = cyc;
        if (q.size() > 0) begin
          e_it = q.pop_front();
          check(act == e_it.a, {e_it.tag, " active"}, int'(act), int'(e_it.a));
          check(samp == e_it.s, {e_it.tag, " sample"}, int'(samp), int'(e_it.s));
        end
      end
      if (act && !prev_act) begin
        if (rises > 0 && rises < NB) begin
          gap = dlen(kl[rises-1]) * DIV;
          if (blen(kl[rises-1]) + 1 > PER)
            check(cyc - last_rise == gap, "R5 overrun spacing", cyc - last_rise, gap);
          else
            check(cyc - last_rise == gap, "R4 period spacing", cyc - last_rise, gap);
        end
        last_rise = cyc;
        rises++;
      end
      prev_act = act;
      if (maddr != prev_addr) begin
        if (last_chg >= 0)
          check((cyc - last_chg) % DIV == 0, "R10 address change timing", (cyc - last_chg) % DIV, 0);
        last_chg = cyc;
      end
      prev_addr = maddr;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(samp == SW'(MIDV), "R9 reset sample", int'(samp), MIDV);
    check(act == 1'b0, "R9 reset active", int'(act), 0);
    check(sv == 1'b0, "R9 reset valid", int'(sv), 0);
    for (int b = 0; b < NB; b++) push_burst(kl[b], b);
    rst = 1'b0;
    // Rewrite the control word in the middle of each burst (R6).
    for (int b = 1; b < NB; b++) begin
      @(posedge act);
      @(negedge clk);
      fcw = FW'(kl[b]);
    end
    wait (q.size() == 0 && rises >= NB);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired, %0d items left", q.size());
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule